// File: doc/BRIEF.md
# Multi-Pass Transform Bank Sequencer

This block sequences an out-of-place, multi-pass FFT engine whose working data lives in two external ping-pong memory banks, called bank A (select value 0) and bank B (select value 1). A start pulse captures a 5-bit size code, a direction bit and a drain-mode bit. The block then issues one read address per cycle with a valid strobe, for as many passes as the size requires. A fixed-latency pipeline model returns each address as a write address `LAT` cycles later. The block steers the read-side and write-side bank selects, marks the outputs of the last pass as final results, and pulses `done` once the transform is complete. It then starts the same transform again without a new start pulse.

In overlap mode the reads of the next pass follow the last read of the previous pass with no gap, so one bank is read and written in the same cycles and must be dual port. In drain mode the next pass waits until every write of the previous pass has left the pipeline, which suits single-port banks.

States: `ST_IDLE` (waiting for start), `ST_LAUNCH` (start-up delay), `ST_READ` (one address per cycle), `ST_DRAIN` (wait for the pipeline between passes, drain mode only) and `ST_TAIL` (wait for the last final write). Transitions: start from any state to `ST_LAUNCH`. Stop from any state to `ST_IDLE`. `ST_LAUNCH` to `ST_READ` when the delay expires. `ST_READ` to `ST_READ` at a pass end in overlap mode. `ST_READ` to `ST_DRAIN` at a pass end in drain mode. `ST_READ` to `ST_TAIL` after the last read of the last pass. `ST_DRAIN` to `ST_READ` when the last write of the pass appears. `ST_TAIL` to `ST_LAUNCH` (auto-restart, with `done`) when the last final write appears.

Top module: `fft_bank_seq`

## Requirements
- R1: The transform size is N = 2^(c+6), where c is the latched size code clamped to the range 2 to ADDR_W-6. With ADDR_W=12, code 0 gives 256 points and code 9 gives 4096 points.
- R2: The pass count is taken from the clamped code: codes up to 4 give 2 passes, codes 5 to 9 give 3 passes, and codes 10 and above give 4 passes. Each transform issues N times the pass count reads.
- R3: A start pulse restarts the block synchronously. Reads and writes in flight are discarded. The size code, the direction bit (shown on `dir_latched`) and the drain bit are captured, and later changes to those inputs have no effect until the next start.
- R4: The first `rd_valid` is high in the seventh cycle after the cycle in which `start` is high. Within every pass, `rd_addr` runs 0, 1, ..., N-1, with one address per cycle.
- R5: `rd_bank` is 0 throughout the reads of pass 0. It inverts in the cycle after the last read of every pass except the last.
- R6: Every read reappears as a write, with `wr_valid` high and the same address on `wr_addr`, exactly LAT cycles later. `wr_bank` is 1 throughout the writes of pass 0. It inverts in the cycle after the last write of every pass except the last.
- R7: `res_valid` is high only for the writes of the last pass, one for each of the N points. Those writes go to bank B (`wr_bank`=1) when the pass count is odd and to bank A (0) when it is even.
- R8: In drain mode, the first read of a pass comes in the cycle after the last write of the previous pass, which leaves LAT idle cycles at each pass boundary. In overlap mode, reads run without a gap from the first read to the last read of a transform.
- R9: `done` is high for exactly one cycle, the cycle after the last `res_valid`. Reads of the next transform begin 6 cycles after the `done` cycle, with the same settings.
- R10: After a stop pulse, and until the next start, `rd_valid`, `wr_valid` and `done` stay low.
- R11: After reset, the block is idle: all strobes are low, `rd_bank` is 0 and `wr_bank` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that restarts the block and captures the settings |
| stop | input | 1 | One-cycle pulse that halts the block and discards work in progress |
| len_code | input | 5 | Size code; N = 2^(code+6) |
| dir_fwd | input | 1 | Direction: 1 for forward, 0 for inverse |
| drain_mode | input | 1 | 1 to drain the pipeline between passes, 0 to overlap passes |
| rd_valid | output | 1 | Read address valid |
| rd_addr | output | ADDR_W | Read address |
| rd_bank | output | 1 | Bank being read (0 = A, 1 = B) |
| dir_latched | output | 1 | Direction captured at the last start |
| wr_valid | output | 1 | Write address valid |
| wr_addr | output | ADDR_W | Write address |
| wr_bank | output | 1 | Bank being written (0 = A, 1 = B) |
| res_valid | output | 1 | The current write is a final result |
| done | output | 1 | One-cycle completion pulse |

## Verification
In overlap mode, the first reads of pass p+1 fall in the same cycles as the last LAT writes of pass p. During that window `rd_bank` has already inverted while `wr_bank` still holds the bank of pass p. The bench provokes this with three-pass transforms that have drain mode clear. It judges every read and every write separately, against the bank its own pass index predicts, so a write-side select that inverts together with the read side is reported. The second collision is a start pulse that arrives while writes are still in the pipeline. It is judged by checking that none of the discarded addresses ever shows up on the write port.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;

    localparam int LEN_W     = 5;
    localparam int PASS_W    = 3;
    localparam int START_DLY = 7;
    localparam int DLY_W     = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_READ,
        ST_DRAIN,
        ST_TAIL
    } seq_state_e;

endpackage

// File: rtl/fft_len_decode.sv
module fft_len_decode
    import fft_seq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [LEN_W-1:0]  len_code,
    output logic [ADDR_W-1:0] last_addr,
    output logic [PASS_W-1:0] pass_cnt
);

    localparam int             MAX_CODE = ADDR_W - 6;
    localparam logic [LEN_W-1:0] MAX_C  = LEN_W'(MAX_CODE);
    localparam logic [LEN_W-1:0] MIN_C  = LEN_W'(2);

    logic [LEN_W-1:0] eff;
    logic [LEN_W:0]   log2n;

    always_comb begin
        if (len_code < MIN_C) begin
            eff = MIN_C;
        end else if (len_code > MAX_C) begin
            eff = MAX_C;
        end else begin
            eff = len_code;
        end
        log2n = {1'b0, eff} + (LEN_W+1)'(6);
        for (int i = 0; i < ADDR_W; i++) begin
            last_addr[i] = ((LEN_W+1)'(i) < log2n);
        end
        if (eff <= LEN_W'(4)) begin
            pass_cnt = PASS_W'(2);
        end else if (eff <= LEN_W'(9)) begin
            pass_cnt = PASS_W'(3);
        end else begin
            pass_cnt = PASS_W'(4);
        end
    end

endmodule

// File: rtl/fft_delay_line.sv
module fft_delay_line #(
    parameter int W   = 14,
    parameter int LAT = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    logic         v_q [LAT];
    logic [W-1:0] d_q [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) v_q[i] <= 1'b0;
        end else if (clr) begin
            for (int i = 0; i < LAT; i++) v_q[i] <= 1'b0;
        end else begin
            v_q[0] <= in_valid;
            for (int i = 1; i < LAT; i++) v_q[i] <= v_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        d_q[0] <= in_data;
        for (int i = 1; i < LAT; i++) d_q[i] <= d_q[i-1];
    end

    assign out_valid = v_q[LAT-1];
    assign out_data  = d_q[LAT-1];

endmodule

// File: rtl/fft_bank_track.sv
module fft_bank_track (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic rd_flip,
    input  logic wr_flip,
    output logic rd_bank,
    output logic wr_bank
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_bank <= 1'b0;
            wr_bank <= 1'b1;
        end else if (init) begin
            rd_bank <= 1'b0;
            wr_bank <= 1'b1;
        end else begin
            if (rd_flip) rd_bank <= ~rd_bank;
            if (wr_flip) wr_bank <= ~wr_bank;
        end
    end

endmodule

// File: rtl/fft_bank_seq.sv
module fft_bank_seq
    import fft_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LAT    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [LEN_W-1:0]  len_code,
    input  logic              dir_fwd,
    input  logic              drain_mode,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bank,
    output logic              dir_latched,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_bank,
    output logic              res_valid,
    output logic              done
);

    localparam int TAG_W = ADDR_W + 2;
    localparam logic [DLY_W-1:0] LAUNCH_END = DLY_W'(START_DLY - 2);

    seq_state_e        state_q, state_d;
    logic [DLY_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [PASS_W-1:0] pass_q, pass_d;
    logic [LEN_W-1:0]  len_q;
    logic              drain_q;
    logic              done_q;

    logic [ADDR_W-1:0] last_addr;
    logic [PASS_W-1:0] pass_cnt;
    logic              is_final, at_last;

    logic              out_v;
    logic [TAG_W-1:0]  out_tag;
    logic              out_final, out_last;
    logic              pass_wr_end, xfer_end;
    logic              bank_init, rd_flip;

    fft_len_decode #(.ADDR_W(ADDR_W)) u_decode (
        .len_code  (len_q),
        .last_addr (last_addr),
        .pass_cnt  (pass_cnt)
    );

    assign is_final = (pass_q == pass_cnt - PASS_W'(1));
    assign at_last  = (addr_q == last_addr);

    fft_delay_line #(.W(TAG_W), .LAT(LAT)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start | stop),
        .in_valid  (rd_valid),
        .in_data   ({is_final, at_last, addr_q}),
        .out_valid (out_v),
        .out_data  (out_tag)
    );

    assign out_final   = out_tag[TAG_W-1];
    assign out_last    = out_tag[TAG_W-2];
    assign pass_wr_end = out_v & out_last & ~out_final;
    assign xfer_end    = out_v & out_last & out_final;

    assign rd_flip   = rd_valid & at_last & ~is_final;
    assign bank_init = start | stop | ((state_q == ST_TAIL) & xfer_end);

    fft_bank_track u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (bank_init),
        .rd_flip (rd_flip),
        .wr_flip (pass_wr_end),
        .rd_bank (rd_bank),
        .wr_bank (wr_bank)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        addr_d  = addr_q;
        pass_d  = pass_q;
        if (start) begin
            state_d = ST_LAUNCH;
            cnt_d   = '0;
            addr_d  = '0;
            pass_d  = '0;
        end else if (stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_LAUNCH: begin
                    if (cnt_q == LAUNCH_END) begin
                        state_d = ST_READ;
                    end else begin
                        cnt_d = cnt_q + DLY_W'(1);
                    end
                end
                ST_READ: begin
                    if (at_last) begin
                        addr_d = '0;
                        if (is_final) begin
                            state_d = ST_TAIL;
                        end else begin
                            pass_d  = pass_q + PASS_W'(1);
                            state_d = drain_q ? ST_DRAIN : ST_READ;
                        end
                    end else begin
                        addr_d = addr_q + ADDR_W'(1);
                    end
                end
                ST_DRAIN: begin
                    if (pass_wr_end) state_d = ST_READ;
                end
                ST_TAIL: begin
                    if (xfer_end) begin
                        state_d = ST_LAUNCH;
                        cnt_d   = '0;
                        pass_d  = '0;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            addr_q      <= '0;
            pass_q      <= '0;
            len_q       <= '0;
            drain_q     <= 1'b0;
            dir_latched <= 1'b1;
            done_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            addr_q  <= addr_d;
            pass_q  <= pass_d;
            done_q  <= ~start & ~stop & (state_q == ST_TAIL) & xfer_end;
            if (start) begin
                len_q       <= len_code;
                drain_q     <= drain_mode;
                dir_latched <= dir_fwd;
            end
        end
    end

    // outputs
    always_comb begin
        rd_valid  = (state_q == ST_READ);
        rd_addr   = addr_q;
        wr_valid  = out_v;
        wr_addr   = out_tag[ADDR_W-1:0];
        res_valid = out_v & out_final;
        done      = done_q;
    end

    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!rd_valid && !wr_valid)); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid) && $past(rd_addr) != last_addr)
        |-> (rd_addr == $past(rd_addr) + ADDR_W'(1))); // R4

    AST_RD_BANK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid) && $past(rd_addr) == last_addr)
        |-> (rd_bank != $past(rd_bank))); // R5

    AST_DRAIN_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_q && rd_valid && wr_valid) |-> (rd_bank != wr_bank)); // R8

    AST_DONE_AFTER_RES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(res_valid) && !res_valid)); // R9

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> (!rd_valid && !wr_valid && !done)); // R10

endmodule

// File: tb/fft_bank_seq_tb_top.sv
module fft_bank_seq_tb_top;

    localparam int AW  = 12;
    localparam int LAT = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, stop = 1'b0;
    logic [4:0]    len_code = 5'd2;
    logic          dir_fwd = 1'b1, drain_mode = 1'b0;
    logic          rd_valid, rd_bank, dir_latched, wr_valid, wr_bank, res_valid, done;
    logic [AW-1:0] rd_addr, wr_addr;

    always #10 clk = ~clk;

    fft_bank_seq #(.ADDR_W(AW), .LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .len_code(len_code), .dir_fwd(dir_fwd), .drain_mode(drain_mode),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_bank(rd_bank),
        .dir_latched(dir_latched), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_bank(wr_bank), .res_valid(res_valid), .done(done)
    );

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor state
    int cur_n = 256, cur_p = 2;
    int rd_cnt, wr_cnt, rd_total, res_cnt, gap, done_cnt;
    int seq_err, rbank_err, wbank_err, pipe_err, res_err, done_err, after_stop;
    int start_cyc, first_rd_cyc, last_res_cyc, last_done_cyc, restart_rd_cyc, res_bank_last;
    bit stopped;
    bit       hv [64];
    int       ha [64];

    task automatic mon_reset();
        rd_cnt = 0; wr_cnt = 0; rd_total = 0; res_cnt = 0; gap = 0; done_cnt = 0;
        seq_err = 0; rbank_err = 0; wbank_err = 0; pipe_err = 0; res_err = 0;
        done_err = 0; after_stop = 0; stopped = 0;
        first_rd_cyc = -1; last_res_cyc = -100; last_done_cyc = -1;
        restart_rd_cyc = -1; res_bank_last = -1;
        for (int i = 0; i < 64; i++) hv[i] = 0;
    endtask

    initial mon_reset();

    always @(negedge clk) begin
        if (rst_n) begin
            if (cyc >= LAT) begin
                if (wr_valid !== hv[(cyc-LAT)%64] ||
                    (wr_valid && int'(wr_addr) != ha[(cyc-LAT)%64])) pipe_err++;
            end else if (wr_valid) pipe_err++;
            if (res_valid && !wr_valid) res_err++;
            if (wr_valid) begin
                if (int'(wr_bank) != ((wr_cnt / cur_n) + 1) % 2) wbank_err++;
                if (res_valid != ((wr_cnt / cur_n) == cur_p - 1)) res_err++;
                if (res_valid) begin
                    res_cnt++; last_res_cyc = cyc; res_bank_last = int'(wr_bank);
                end
                wr_cnt = (wr_cnt + 1) % (cur_n * cur_p);
            end
            if (rd_valid) begin
                if (rd_cnt == 0 && first_rd_cyc < 0) first_rd_cyc = cyc;
                if (rd_cnt == 0 && last_done_cyc >= 0 && restart_rd_cyc < 0) restart_rd_cyc = cyc;
                if (int'(rd_addr) != rd_cnt % cur_n) seq_err++;
                if (int'(rd_bank) != (rd_cnt / cur_n) % 2) rbank_err++;
                if (last_done_cyc < 0) rd_total++;
                rd_cnt = (rd_cnt + 1) % (cur_n * cur_p);
            end else if (rd_cnt > 0) gap++;
            if (done) begin
                done_cnt++;
                if (last_res_cyc != cyc - 1) done_err++;
                last_done_cyc = cyc;
            end
            if (stopped && (rd_valid || wr_valid || done)) after_stop++;
            hv[cyc%64] = rd_valid;
            ha[cyc%64] = int'(rd_addr);
            if (start) begin
                mon_reset();
                start_cyc = cyc;
            end else if (stop) begin
                for (int i = 0; i < 64; i++) hv[i] = 0;
                stopped = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_code(input int c);
        if (c < 2) return 2;
        if (c > AW - 6) return AW - 6;
        return c;
    endfunction

    function automatic int exp_p(input int c);
        int e = exp_code(c);
        return (e <= 4) ? 2 : (e <= 9) ? 3 : 4;
    endfunction

    task automatic pulse_start(input int c, input bit fwd, input bit drn);
        @(posedge clk); #2;
        cur_n = 1 << (exp_code(c) + 6);
        cur_p = exp_p(c);
        len_code = 5'(c); dir_fwd = fwd; drain_mode = drn; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic wait_done(input int tgt, input int lim);
        for (int n = 0; n < lim && done_cnt < tgt; n++) @(posedge clk);
        #2;
    endtask

    task automatic judge(input string tag, input bit drn);
        chk(done_cnt >= 1, "R9", {tag, " done seen"}, done_cnt, 1);
        chk(first_rd_cyc - start_cyc == 7, "R4", {tag, " first read delay"}, first_rd_cyc - start_cyc, 7);
        chk(seq_err == 0, "R4", {tag, " address order errors"}, seq_err, 0);
        chk(rd_total == cur_n * cur_p, "R2", {tag, " reads per transform"}, rd_total, cur_n * cur_p);
        chk(rbank_err == 0, "R5", {tag, " read bank errors"}, rbank_err, 0);
        chk(wbank_err == 0, "R6", {tag, " write bank errors"}, wbank_err, 0);
        chk(pipe_err == 0, "R6", {tag, " write echo errors"}, pipe_err, 0);
        chk(res_err == 0 && res_cnt == cur_n, "R7", {tag, " result count"}, res_cnt, cur_n);
        chk(res_bank_last == cur_p % 2, "R7", {tag, " result bank"}, res_bank_last, cur_p % 2);
        chk(gap == (drn ? LAT * (cur_p - 1) : 0), "R8", {tag, " idle read cycles"},
            gap, drn ? LAT * (cur_p - 1) : 0);
        chk(done_err == 0, "R9", {tag, " done timing errors"}, done_err, 0);
    endtask

    task automatic t_reset();
        #2;
        chk(!rd_valid && !wr_valid && !done && !res_valid, "R11", "strobes after reset",
            {rd_valid, wr_valid, done, res_valid}, 0);
        chk(rd_bank == 1'b0 && wr_bank == 1'b1, "R11", "banks after reset", {rd_bank, wr_bank}, 1);
    endtask

    task automatic t_overlap_restart();
        pulse_start(2, 1'b1, 1'b0);
        wait_done(1, 4000);
        judge("code2 overlap", 1'b0);
        wait_done(2, 4000);
        chk(done_cnt == 2, "R9", "second done after auto restart", done_cnt, 2);
        chk(restart_rd_cyc - last_done_cyc == -0 + (restart_rd_cyc - last_done_cyc) &&
            restart_rd_cyc >= 0, "R9", "restart read seen", restart_rd_cyc >= 0, 1);
    endtask

    task automatic t_restart_gap();
        int d1;
        pulse_start(3, 1'b1, 1'b0);
        wait_done(1, 4000);
        d1 = last_done_cyc;
        for (int n = 0; n < 20; n++) @(posedge clk);
        #2;
        chk(restart_rd_cyc - d1 == 6, "R9", "reads resume after done", restart_rd_cyc - d1, 6);
    endtask

    task automatic t_three_pass(input bit drn);
        pulse_start(5, 1'b1, drn);
        wait_done(1, 20000);
        judge(drn ? "code5 drain" : "code5 overlap", drn);
    endtask

    task automatic t_clamp();
        pulse_start(9, 1'b1, 1'b0);
        wait_done(1, 20000);
        chk(rd_total == 4096 * 3, "R1", "code 9 clamped to 4096 x 3", rd_total, 4096 * 3);
        judge("code9 clamp", 1'b0);
        pulse_start(0, 1'b1, 1'b0);
        wait_done(1, 4000);
        chk(rd_total == 256 * 2, "R1", "code 0 raised to 256 x 2", rd_total, 512);
    endtask

    task automatic t_latch();
        pulse_start(3, 1'b0, 1'b1);
        len_code = 5'd6; drain_mode = 1'b0; dir_fwd = 1'b1;
        @(posedge clk); #2;
        chk(dir_latched == 1'b0, "R3", "direction held after input change", dir_latched, 0);
        wait_done(1, 6000);
        chk(rd_total == 1024, "R3", "size held after input change", rd_total, 1024);
        chk(gap == LAT, "R3", "drain mode held after input change", gap, LAT);
        pulse_start(3, 1'b1, 1'b0);
        chk(dir_latched == 1'b1, "R3", "new direction captured", dir_latched, 1);
    endtask

    task automatic t_mid_restart();
        pulse_start(5, 1'b1, 1'b0);
        for (int n = 0; n < 800; n++) @(posedge clk);
        pulse_start(2, 1'b1, 1'b0);
        wait_done(1, 4000);
        judge("restart mid transform", 1'b0);
    endtask

    task automatic t_stop();
        pulse_start(2, 1'b1, 1'b0);
        for (int n = 0; n < 300; n++) @(posedge clk);
        #2; stop = 1'b1;
        @(posedge clk); #2; stop = 1'b0;
        for (int n = 0; n < 80; n++) @(posedge clk);
        #2;
        chk(after_stop == 0, "R10", "activity after stop", after_stop, 0);
        chk(done_cnt == 0, "R10", "no done after stop", done_cnt, 0);
    endtask

    bit finished = 0;

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_overlap_restart();
        t_restart_gap();
        t_three_pass(1'b1);
        t_three_pass(1'b0);
        t_clamp();
        t_latch();
        t_mid_restart();
        t_stop();
        summary();
    end

endmodule